// File: doc/BRIEF.md
# Sequential Integer Square Root

This unit computes the integer square root of a 32-bit unsigned radicand. A one-cycle start pulse, given while the unit is idle, captures the radicand. The unit then settles one root bit per clock, from the most significant bit down. For each bit it tests whether a candidate amount can be taken out of the running remainder. Once all 16 bits are settled, the unit raises a one-cycle done pulse. At that point it presents a 16-bit root and a 17-bit remainder, and both stay on the outputs until the next accepted start.

The unit uses a restoring scheme. A one-hot weight register shifts right by two places each step. A second register holds the partial root, kept pre-shifted so that adding the weight to it forms the trial amount. A candidate bit is kept only when the remainder would stay nonnegative.

Top module: `isqrt_serial`

## Requirements
- R1: After reset, busy and done are 0, and root and rem are 0.
- R2: A start pulse seen while busy is 0 is accepted on that clock edge, and busy is 1 from the next cycle. Done is 1 exactly 16 rising edges after the accepting edge, and busy falls on that same edge.
- R3: Done is high for exactly one cycle per accepted start. While the unit is idle and start is low, root and rem do not change, whatever the radicand input does.
- R4: A start pulse given while busy is 1 has no effect: the running computation finishes on time with the result for the radicand captured at acceptance.
- R5: When done is 1, root*root + rem equals the captured radicand.
- R6: When done is 1, rem is at most 2*root. Together with R5 this makes root the largest integer whose square does not exceed the radicand.
- R7: For a radicand that is a perfect square k*k, root is k and rem is 0. This includes k = 65535, which gives radicand 0xFFFE0001.
- R8: A radicand of 0 gives root 0 and rem 0. A radicand of 1 gives root 1 and rem 0. A radicand of 0xFFFFFFFF gives root 0xFFFF and rem 0x1FFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a computation when the unit is idle |
| radicand | input | 32 | Unsigned value whose root is wanted; captured on the accepting edge |
| busy | output | 1 | High while root bits are being settled |
| done | output | 1 | One-cycle pulse marking a valid result |
| root | output | 16 | Integer square root |
| rem | output | 17 | Radicand minus root squared |

## Verification
The bench targets the extremes of the trial comparison. The input 0xFFFFFFFF pushes the trial sum to its widest value; a comparator one bit too narrow would wrap and set root bits that should stay clear. A remainder of exactly zero, on perfect squares and on inputs 0 and 1, shows whether an equal comparison is treated as a fit. An off-by-one there would give a root one too small and a remainder of 2q+1.

The bench also measures the latency edge by edge. A counter that is off by one would raise done a cycle early or late, or would leave the last bit unsettled. A start pulse in the middle of a run catches a unit that reloads while busy. Stirring the radicand input after done catches outputs that do not hold.

// File: rtl/isqrt_serial.sv
module isqrt_serial #(
  parameter int RAD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RAD_W-1:0]   radicand,
  output logic               busy,
  output logic               done,
  output logic [RAD_W/2-1:0] root,
  output logic [RAD_W/2:0]   rem
);
  localparam int ROOT_W = RAD_W / 2;
  localparam int CNT_W  = (ROOT_W > 1) ? $clog2(ROOT_W) : 1;

  logic [RAD_W-1:0] acc;
  logic [RAD_W-1:0] part;
  logic [RAD_W-1:0] wgt;
  logic [CNT_W-1:0] cnt;

  logic [RAD_W:0] trial;
  logic           fits;

  assign trial = {1'b0, part} + {1'b0, wgt};
  assign fits  = ({1'b0, acc} >= trial);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      part <= '0;
      wgt  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc  <= radicand;
          part <= '0;
          wgt  <= {2'b01, {(RAD_W-2){1'b0}}};
          cnt  <= CNT_W'(ROOT_W - 1);
          busy <= 1'b1;
        end
      end else begin
        if (fits) begin
          acc  <= acc - trial[RAD_W-1:0];
          part <= (part >> 1) + wgt;
        end else begin
          part <= part >> 1;
        end
        wgt <= wgt >> 2;
        cnt <= cnt - 1'b1;
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign root = part[ROOT_W-1:0];
  assign rem  = acc[ROOT_W:0];

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r2_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && !done));
  a_r2_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0) |=> (!busy && done));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(root) && $stable(rem)));
  a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (acc <= $past(acc)));
  a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem <= {root, 1'b0}));
endmodule

// File: tb/isqrt_serial_tb.sv
module isqrt_serial_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] radicand = '0;
  logic        busy;
  logic        done;
  logic [15:0] root;
  logic [16:0] rem;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  isqrt_serial #(.RAD_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .radicand(radicand),
    .busy(busy), .done(done), .root(root), .rem(rem)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_root(input longint d);
    longint lo = 0;
    longint hi = 65535;
    while (lo < hi) begin
      longint mid = (lo + hi + 1) / 2;
      if (mid * mid <= d) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  task automatic run(input logic [31:0] d, input bit poke_busy,
                     output longint r, output longint m, output int cyc);
    @(negedge clk);
    radicand = d;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int k = 0; k < 40; k++) begin
      if (poke_busy && k == 5) begin
        radicand = ~d;
        start = 1'b1;
      end
      if (poke_busy && k == 6) start = 1'b0;
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
    end
    start = 1'b0;
    r = root;
    m = rem;
  endtask

  task automatic check_value(input string req, input logic [31:0] d);
    longint r, m, er;
    int cyc;
    run(d, 1'b0, r, m, cyc);
    er = ref_root(d);
    check(req, $sformatf("root of %0h", d), r, er);
    check("R5", $sformatf("identity for %0h", d), r * r + m, longint'(d));
    check("R6", $sformatf("bound for %0h", d), longint'(m <= 2 * r), 1);
  endtask

  task automatic t_reset();
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "root after reset", root, 0);
    check("R1", "rem after reset", rem, 0);
  endtask

  task automatic t_edges();
    longint r, m;
    int cyc;
    run(32'd0, 1'b0, r, m, cyc);
    check("R8", "root of 0", r, 0);
    check("R8", "rem of 0", m, 0);
    run(32'd1, 1'b0, r, m, cyc);
    check("R8", "root of 1", r, 1);
    check("R8", "rem of 1", m, 0);
    run(32'hFFFF_FFFF, 1'b0, r, m, cyc);
    check("R8", "root of max", r, 65535);
    check("R8", "rem of max", m, 131070);
    check_value("R5", 32'd2);
    check_value("R5", 32'd3);
    check_value("R6", 32'd8);
  endtask

  task automatic t_squares();
    longint ks[6] = '{2, 3, 255, 256, 4097, 65535};
    foreach (ks[i]) begin
      longint r, m;
      int cyc;
      run(32'(ks[i] * ks[i]), 1'b0, r, m, cyc);
      check("R7", $sformatf("root of %0d^2", ks[i]), r, ks[i]);
      check("R7", $sformatf("rem of %0d^2", ks[i]), m, 0);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) check_value("R5", $urandom());
  endtask

  task automatic t_timing();
    longint r, m;
    int cyc;
    run(32'd1000, 1'b0, r, m, cyc);
    check("R2", "edges to done", cyc, 16);
    check("R2", "busy low at done", busy, 0);
    @(negedge clk);
    check("R3", "done is one cycle", done, 0);
  endtask

  task automatic t_busy_start();
    longint r, m;
    int cyc;
    run(32'd12345678, 1'b1, r, m, cyc);
    check("R4", "edges with start during run", cyc, 16);
    check("R4", "root unaffected", r, ref_root(12345678));
    check("R4", "rem unaffected", m, 12345678 - ref_root(12345678) * ref_root(12345678));
  endtask

  task automatic t_hold();
    longint r, m;
    int cyc;
    run(32'd99, 1'b0, r, m, cyc);
    for (int i = 0; i < 6; i++) begin
      radicand = $urandom();
      @(negedge clk);
    end
    check("R3", "root held", root, 9);
    check("R3", "rem held", rem, 18);
    check("R3", "no extra done", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_edges();
    t_squares();
    t_random();
    t_timing();
    t_busy_start();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule